// File: doc/BRIEF.md
# Instruction Decode Control Unit

This block turns one 16-bit instruction word of a small register-to-register load/store machine into the full set of datapath control lines. It is purely combinational. The instruction fetched from memory drives its input directly, and in the same cycle its outputs set up the register file read ports, the register write port, the ALU function, the memory strobes and the write-back source multiplexer.

Seven instructions are decoded: an 8-bit immediate move, a word load, a word store and four ALU operations. The store instruction takes the data it writes to memory from the destination field, so that field has two uses. Write-back picks one of three sources: the ALU result, memory read data or the instruction immediate. Any other opcode is made harmless. It writes no register and issues no memory access. Every output that does not matter for a given instruction is still driven to zero, so the outputs are always exact and predictable.

Instruction fields by bit position: opcode in 15:12; a future-use bit in 11; destination/data register in 10:8; in register format, first operand in 6:4 and second operand in 2:0, with bits 7 and 3 zero; in immediate format, an unsigned constant in 7:0.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: `wr_sel` always equals instruction bits 10:8, whatever the opcode.
- R2: Opcode 0000 (immediate move) gives `wb_src`=10 (immediate), `wr_en`=1, `mem_wr`=0, `mem_rd`=0, `alu_fn`=00, `rd_sel_a`=0 and `rd_sel_b`=0.
- R3: Opcode 0100 (store) gives `rd_sel_a`=bits 6:4, `rd_sel_b`=bits 10:8, `mem_wr`=1, `mem_rd`=0, `wr_en`=0, `wb_src`=00 and `alu_fn`=00.
- R4: Opcode 0101 (load) gives `rd_sel_a`=bits 6:4, `rd_sel_b`=0, `mem_rd`=1, `mem_wr`=0, `wr_en`=1, `wb_src`=01 (memory) and `alu_fn`=00.
- R5: Opcodes 10xx (ALU) give `rd_sel_a`=bits 6:4, `rd_sel_b`=bits 2:0, `alu_fn`=opcode bits 13:12 (00 add, 01 subtract, 10 AND, 11 XOR), `wr_en`=1, `wb_src`=00 (ALU) and both memory strobes 0.
- R6: Bit 11 has no effect on any output, bits 7 and 3 have no effect for any opcode, and the immediate byte 7:0 has no effect on any output for the immediate move.
- R7: The unsupported opcodes 0001, 0010, 0011, 0110, 0111 and 11xx drive `wr_en`, `mem_wr`, `mem_rd`, `alu_fn`, `rd_sel_a`, `rd_sel_b` and `wb_src` all to zero.
- R8: `mem_wr` and `mem_rd` are never both high, `mem_wr` high implies `wr_en` low, and `wb_src` is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word to decode |
| alu_fn | output | 2 | ALU function select |
| rd_sel_a | output | 3 | Register file read select, port A (ALU A / memory address) |
| rd_sel_b | output | 3 | Register file read select, port B (ALU B / store data) |
| wr_sel | output | 3 | Register file write select |
| wr_en | output | 1 | Register file write enable |
| mem_wr | output | 1 | Memory store strobe |
| mem_rd | output | 1 | Memory load strobe |
| wb_src | output | 2 | Write-back source: 00 ALU, 01 memory, 10 immediate |

## Verification
The bench builds the block with its package defaults: a 16-bit instruction, 4-bit opcode and 3-bit register fields. At these values the opcode space has only 16 codes, so every opcode, including every unsupported one, is swept with several field patterns. The bench also toggles the future-use bit, the reserved zero bits and the immediate byte against an unmodified base word, which shows that outputs do not depend on those bits.

// File: rtl/idc_pkg.sv
package idc_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int REG_W   = 3;
    localparam int ALU_W   = 2;
    localparam int WBS_W   = 2;
    localparam int IMM_W   = 8;

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RD_LSB  = 8;
    localparam int RA_LSB  = 4;
    localparam int RB_LSB  = 0;

    localparam logic [OPC_W-1:0] OPC_IMM    = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_STORE  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 4'b0101;
    localparam logic [OPC_W-ALU_W-1:0] OPC_ALU_HI = 2'b10;

    typedef logic [REG_W-1:0] reg_sel_t;

    typedef enum logic [ALU_W-1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_AND = 2'b10,
        FN_XOR = 2'b11
    } alu_fn_e;

    typedef enum logic [WBS_W-1:0] {
        WB_ALU = 2'b00,
        WB_MEM = 2'b01,
        WB_IMM = 2'b10
    } wb_src_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_IMM,
        CLS_STORE,
        CLS_LOAD,
        CLS_ALU
    } op_class_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        reg_sel_t         rd;
        reg_sel_t         ra;
        reg_sel_t         rb;
    } instr_fields_t;

    typedef struct packed {
        alu_fn_e  fn;
        reg_sel_t sel_a;
        reg_sel_t sel_b;
        reg_sel_t sel_w;
        logic     wr_en;
        logic     mem_wr;
        logic     mem_rd;
        wb_src_e  wb;
    } ctl_word_t;

    function automatic op_class_e classify_opc(input logic [OPC_W-1:0] opc);
        op_class_e c;
        if (opc == OPC_IMM)
            c = CLS_IMM;
        else if (opc == OPC_STORE)
            c = CLS_STORE;
        else if (opc == OPC_LOAD)
            c = CLS_LOAD;
        else if (opc[OPC_W-1:ALU_W] == OPC_ALU_HI)
            c = CLS_ALU;
        else
            c = CLS_NONE;
        return c;
    endfunction

endpackage

// File: rtl/idc_fields.sv
module idc_fields
    import idc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output instr_fields_t      fields
);
    // bit 11 and the zero bits 7 and 3 are not decoded
    logic unused_bits;
    assign unused_bits = ^{instr[OPC_LSB-1], instr[RA_LSB+REG_W], instr[RB_LSB+REG_W]};

    always_comb begin
        fields.opc = instr[OPC_LSB +: OPC_W];
        fields.rd  = instr[RD_LSB  +: REG_W];
        fields.ra  = instr[RA_LSB  +: REG_W];
        fields.rb  = instr[RB_LSB  +: REG_W];
    end
endmodule

// File: rtl/idc_classify.sv
module idc_classify
    import idc_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output op_class_e        cls
);
    always_comb cls = classify_opc(opc);

    // R7: anything outside the four supported groups lands in CLS_NONE
    always_comb begin
        if (!$isunknown(opc) && opc[OPC_W-1] && opc[OPC_W-2])
            a_r7_top_codes_none: assert (cls == CLS_NONE)
                else $error("opcode 11xx not classed as none");
    end
endmodule

// File: rtl/idc_ctrl_gen.sv
module idc_ctrl_gen
    import idc_pkg::*;
(
    input  op_class_e     cls,
    input  instr_fields_t fields,
    output ctl_word_t     ctl
);
    always_comb begin
        ctl        = '0;
        ctl.sel_w  = fields.rd;
        case (cls)
            CLS_IMM: begin
                ctl.wr_en = 1'b1;
                ctl.wb    = WB_IMM;
            end
            CLS_STORE: begin
                ctl.sel_a  = fields.ra;
                ctl.sel_b  = fields.rd;
                ctl.mem_wr = 1'b1;
            end
            CLS_LOAD: begin
                ctl.sel_a  = fields.ra;
                ctl.mem_rd = 1'b1;
                ctl.wr_en  = 1'b1;
                ctl.wb     = WB_MEM;
            end
            CLS_ALU: begin
                ctl.sel_a = fields.ra;
                ctl.sel_b = fields.rb;
                ctl.fn    = alu_fn_e'(fields.opc[ALU_W-1:0]);
                ctl.wr_en = 1'b1;
                ctl.wb    = WB_ALU;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (!$isunknown(fields)) begin
            // R3: a store never also writes the register file
            a_r3_store_no_wb: assert (!(ctl.mem_wr && ctl.wr_en))
                else $error("store with register write");
            // R4: a load always writes back memory data
            a_r4_load_path: assert (!ctl.mem_rd || (ctl.wr_en && ctl.wb == WB_MEM))
                else $error("load without memory write-back");
            // R2: immediate write-back only for the immediate class
            a_r2_imm_class: assert ((ctl.wb == WB_IMM) == (cls == CLS_IMM))
                else $error("immediate source mismatch");
        end
    end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
    import idc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [ALU_W-1:0]   alu_fn,
    output logic [REG_W-1:0]   rd_sel_a,
    output logic [REG_W-1:0]   rd_sel_b,
    output logic [REG_W-1:0]   wr_sel,
    output logic               wr_en,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic [WBS_W-1:0]   wb_src
);
    instr_fields_t fields;
    op_class_e     cls;
    ctl_word_t     ctl;

    idc_fields u_fields (
        .instr  (instr),
        .fields (fields)
    );

    idc_classify u_classify (
        .opc (fields.opc),
        .cls (cls)
    );

    idc_ctrl_gen u_ctrl_gen (
        .cls    (cls),
        .fields (fields),
        .ctl    (ctl)
    );

    assign alu_fn   = ctl.fn;
    assign rd_sel_a = ctl.sel_a;
    assign rd_sel_b = ctl.sel_b;
    assign wr_sel   = ctl.sel_w;
    assign wr_en    = ctl.wr_en;
    assign mem_wr   = ctl.mem_wr;
    assign mem_rd   = ctl.mem_rd;
    assign wb_src   = ctl.wb;

    logic supported;
    assign supported = (instr[OPC_LSB +: OPC_W] == OPC_IMM)
                    || (instr[OPC_LSB +: OPC_W] == OPC_STORE)
                    || (instr[OPC_LSB +: OPC_W] == OPC_LOAD)
                    || (instr[INSTR_W-1 -: 2] == OPC_ALU_HI);

    always_comb begin
        if (!$isunknown(instr)) begin
            // R1
            a_r1_wsel_field: assert (wr_sel == instr[RD_LSB +: REG_W])
                else $error("write select does not follow bits 10:8");
            // R7
            a_r7_unknown_quiet: assert (supported || !(wr_en || mem_wr || mem_rd))
                else $error("unsupported opcode has side effects");
            // R8
            a_r8_strobe_excl: assert (!(mem_wr && mem_rd))
                else $error("both memory strobes high");
            a_r8_wb_legal: assert (wb_src != 2'b11)
                else $error("illegal write-back source");
            // R5
            a_r5_alu_fn: assert (!(instr[INSTR_W-1 -: 2] == OPC_ALU_HI)
                                 || alu_fn == instr[OPC_LSB +: ALU_W])
                else $error("ALU function not taken from opcode");
        end
    end
endmodule

// File: tb/instr_ctrl_decoder_bench.sv
module instr_ctrl_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [1:0]  alu_fn;
    logic [2:0]  rd_sel_a, rd_sel_b, wr_sel;
    logic        wr_en, mem_wr, mem_rd;
    logic [1:0]  wb_src;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    instr_ctrl_decoder u_instr_ctrl_decoder (
        .instr    (instr),
        .alu_fn   (alu_fn),
        .rd_sel_a (rd_sel_a),
        .rd_sel_b (rd_sel_b),
        .wr_sel   (wr_sel),
        .wr_en    (wr_en),
        .mem_wr   (mem_wr),
        .mem_rd   (mem_rd),
        .wb_src   (wb_src)
    );

    // packed view {alu_fn, sel_a, sel_b, wr_sel, wr_en, mem_wr, mem_rd, wb_src}
    function automatic logic [15:0] pk(input logic [1:0] f, input logic [2:0] a,
                                       input logic [2:0] b, input logic [2:0] w,
                                       input logic we, input logic mw,
                                       input logic mr, input logic [1:0] wb);
        return {f, a, b, w, we, mw, mr, wb};
    endfunction

    function automatic logic [15:0] outs();
        return {alu_fn, rd_sel_a, rd_sel_b, wr_sel, wr_en, mem_wr, mem_rd, wb_src};
    endfunction

    // reference model written from the requirements
    function automatic logic [15:0] model(input logic [15:0] ins);
        logic [2:0] d = ins[10:8];
        logic [2:0] a = ins[6:4];
        logic [2:0] b = ins[2:0];
        case (ins[15:12])
            4'b0000: return pk(2'b00, 3'd0, 3'd0, d, 1'b1, 1'b0, 1'b0, 2'b10); // R2
            4'b0100: return pk(2'b00, a,    d,    d, 1'b0, 1'b1, 1'b0, 2'b00); // R3
            4'b0101: return pk(2'b00, a,    3'd0, d, 1'b1, 1'b0, 1'b1, 2'b01); // R4
            4'b1000, 4'b1001, 4'b1010, 4'b1011:
                     return pk(ins[13:12], a, b,  d, 1'b1, 1'b0, 1'b0, 2'b00); // R5
            default: return pk(2'b00, 3'd0, 3'd0, d, 1'b0, 1'b0, 1'b0, 2'b00); // R7
        endcase
    endfunction

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] ins;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 16'h0109, pk(2'b00, 3'd0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0, 2'b10)}, // R2
        '{4'd2, 16'h02AB, pk(2'b00, 3'd0, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0, 2'b10)}, // R2
        '{4'd3, 16'h4310, pk(2'b00, 3'd1, 3'd3, 3'd3, 1'b0, 1'b1, 1'b0, 2'b00)}, // R3
        '{4'd4, 16'h5310, pk(2'b00, 3'd1, 3'd0, 3'd3, 1'b1, 1'b0, 1'b1, 2'b01)}, // R4
        '{4'd5, 16'h8332, pk(2'b00, 3'd3, 3'd2, 3'd3, 1'b1, 1'b0, 1'b0, 2'b00)}, // R5 add
        '{4'd5, 16'h9412, pk(2'b01, 3'd1, 3'd2, 3'd4, 1'b1, 1'b0, 1'b0, 2'b00)}, // R5 sub
        '{4'd5, 16'hA143, pk(2'b10, 3'd4, 3'd3, 3'd1, 1'b1, 1'b0, 1'b0, 2'b00)}, // R5 and
        '{4'd5, 16'hB277, pk(2'b11, 3'd7, 3'd7, 3'd2, 1'b1, 1'b0, 1'b0, 2'b00)}, // R5 xor
        '{4'd7, 16'h1234, pk(2'b00, 3'd0, 3'd0, 3'd2, 1'b0, 1'b0, 1'b0, 2'b00)}, // R7
        '{4'd7, 16'hF7FF, pk(2'b00, 3'd0, 3'd0, 3'd7, 1'b0, 1'b0, 1'b0, 2'b00)}, // R7
        '{4'd7, 16'h6555, pk(2'b00, 3'd0, 3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 2'b00)}, // R7
        '{4'd6, 16'h0FFF, pk(2'b00, 3'd0, 3'd0, 3'd7, 1'b1, 1'b0, 1'b0, 2'b10)}  // R6
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] ins);
        @(negedge clk);
        instr = ins;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state: zero word decodes as immediate move into register 0 (R2)
        check(2, "reset word", outs(), pk(2'b00, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 2'b10));

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ins);
            check(int'(VECS[i].req), "table", outs(), VECS[i].exp);
        end

        // every opcode with several field patterns; R1 and R8 invariants
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 3; p++) begin
                logic [15:0] w;
                w = {op[3:0], 12'h000} | (p == 0 ? 16'h0000 : (p == 1 ? 16'h0765 : 16'h0A3E));
                apply(w);
                check(7, "opcode sweep (R2-R5,R7)", outs(), model(w));
                check(1, "R1 write select", {13'd0, wr_sel}, {13'd0, w[10:8]});
                check(8, "R8 invariants",
                      {15'd0, !(mem_wr && mem_rd) && !(mem_wr && wr_en) && wb_src != 2'b11},
                      16'd1);
            end
        end

        // R6: future-use bit and zero bits have no effect
        for (int op = 0; op < 16; op++) begin
            logic [15:0] base, flip, ref_out;
            base = {op[3:0], 12'h352};
            apply(base);
            ref_out = outs();
            flip = base ^ 16'h0888;
            apply(flip);
            check(6, "R6 ignored bits", outs(), ref_out);
        end

        // R6: immediate byte has no effect on immediate move
        apply(16'h0400);
        begin
            logic [15:0] ref_imm;
            ref_imm = outs();
            apply(16'h04FF);
            check(6, "R6 immediate byte", outs(), ref_imm);
            apply(16'h0CA5);
            check(6, "R6 immediate byte and bit 11", outs(), ref_imm);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule